// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block keeps the single reservation that backs a load-exclusive / store-exclusive pair for one processor. A load-exclusive request records the address of its aligned eight-byte granule as the reservation tag and marks the reservation live. A later store-exclusive request is judged against that tag in the same cycle. The answer is a status bit: 0 means the store may write memory, 1 means it must not.

Every store-exclusive consumes the reservation, whether it passes or fails. A clear input, typically pulsed on exception entry or a context switch, drops the reservation. Because the tag covers two adjacent 32-bit words, a paired double-word exclusive at address A also protects A+4 without a second tag. The memory access itself is not part of this block.

Top module: `excl_resv_monitor`

## Requirements
- R1: Out of reset there is no reservation, so a store-exclusive with no prior load-exclusive returns status 1. A synchronous reset also drops a live reservation.
- R2: After a load-exclusive at address A, a store-exclusive at A in a later cycle returns status 0.
- R3: Addresses are compared with bits [2:0] ignored. A store-exclusive anywhere in the same 8-byte granule as the load (A, A+4, A+7) passes. This includes the top granule 0xFFFFFFF8..0xFFFFFFFF.
- R4: A store-exclusive whose address bits [31:3] differ from the tag returns status 1. Examples are the next granule up and the one below.
- R5: A passing store-exclusive drops the reservation, so a repeat store-exclusive to the same granule returns status 1.
- R6: A failing store-exclusive also drops the reservation, so a following store-exclusive to the reserved granule returns status 1.
- R7: A pulse on the clear input drops the reservation, so the next store-exclusive returns status 1.
- R8: A newer load-exclusive replaces the tag. The older granule then fails and the newer one passes.
- R9: The status is combinational and valid in the same cycle as the store-exclusive request. It is computed from the reservation as it stood before that cycle's clock edge.
- R10: When requests coincide, clear outranks load and load outranks store when the next reservation is decided. A store is always judged on the prior reservation. With load and store together, the new load's tag survives. With clear and load together, nothing survives.
- R11: The status output is 0 in every cycle without a store-exclusive request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ldx_req | input | 1 | Load-exclusive request |
| ldx_addr | input | 32 | Load-exclusive byte address |
| stx_req | input | 1 | Store-exclusive request |
| stx_addr | input | 32 | Store-exclusive byte address |
| resv_clr | input | 1 | Drop the reservation |
| stx_fail | output | 1 | Store-exclusive status: 1 fail, 0 pass |

## Verification
A store-exclusive can share its cycle with either a load-exclusive or a clear pulse. In both cases the store must be judged on the old reservation, while the next state follows the load/clear priority. The bench provokes each pairing after an established reservation. It scores the status in that same cycle, and then issues a follow-up store to show which reservation survived: the new load's granule, or none after a clear. It also drives clear and load together and confirms that a later store to the loaded granule fails.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

  // Next-state action for the reservation register.
  typedef enum logic [1:0] {
    RESV_HOLD = 2'd0,
    RESV_SET  = 2'd1,
    RESV_DROP = 2'd2
  } resv_act_e;

endpackage

// File: rtl/excl_granule_align.sv
module excl_granule_align #(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 3
) (
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);

  // Zero the byte-within-granule bits, keep the rest.
  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    if (b < GRAN_LSB) begin : g_low
      assign addr_out[b] = 1'b0;
    end else begin : g_keep
      assign addr_out[b] = addr_in[b];
    end
  end

endmodule

// File: rtl/excl_resv_ctrl.sv
module excl_resv_ctrl
  import excl_mon_pkg::*;
(
  input  logic      ld_req,
  input  logic      st_req,
  input  logic      clr_req,
  output resv_act_e act
);

  // Priority: clear, then load, then store.
  always_comb begin
    if (clr_req)     act = RESV_DROP;
    else if (ld_req) act = RESV_SET;
    else if (st_req) act = RESV_DROP;
    else             act = RESV_HOLD;
  end

endmodule

// File: rtl/excl_resv_store.sv
module excl_resv_store
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  resv_act_e         act,
  input  logic [ADDR_W-1:0] new_tag,
  output logic [ADDR_W-1:0] tag,
  output logic              live
);

  // An empty reservation holds the all-ones tag.
  always_ff @(posedge clk) begin
    if (rst) begin
      tag  <= '1;
      live <= 1'b0;
    end else begin
      unique case (act)
        RESV_SET: begin
          tag  <= new_tag;
          live <= 1'b1;
        end
        RESV_DROP: begin
          tag  <= '1;
          live <= 1'b0;
        end
        default: begin
          tag  <= tag;
          live <= live;
        end
      endcase
    end
  end

endmodule

// File: rtl/excl_resv_monitor.sv
module excl_resv_monitor
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int GRANULE_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ldx_req,
  input  logic [ADDR_W-1:0] ldx_addr,
  input  logic              stx_req,
  input  logic [ADDR_W-1:0] stx_addr,
  input  logic              resv_clr,
  output logic              stx_fail
);

  localparam int GRAN_LSB = $clog2(GRANULE_BYTES);

  logic [ADDR_W-1:0] ld_gran;
  logic [ADDR_W-1:0] st_gran;
  logic [ADDR_W-1:0] cur_tag;
  logic              cur_live;
  resv_act_e         nxt_act;
  logic              hit;

  excl_granule_align #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_ld_align (
    .addr_in (ldx_addr),
    .addr_out(ld_gran)
  );

  excl_granule_align #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_st_align (
    .addr_in (stx_addr),
    .addr_out(st_gran)
  );

  excl_resv_ctrl u_ctrl (
    .ld_req (ldx_req),
    .st_req (stx_req),
    .clr_req(resv_clr),
    .act    (nxt_act)
  );

  excl_resv_store #(.ADDR_W(ADDR_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .act    (nxt_act),
    .new_tag(ld_gran),
    .tag    (cur_tag),
    .live   (cur_live)
  );

  assign hit      = cur_live && (cur_tag == st_gran);
  assign stx_fail = stx_req && !hit;

endmodule

// File: rtl/excl_resv_monitor_chk.sv
module excl_resv_monitor_chk #(
  parameter int ADDR_W        = 32,
  parameter int GRANULE_BYTES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ldx_req,
  input logic [ADDR_W-1:0] ldx_addr,
  input logic              stx_req,
  input logic [ADDR_W-1:0] stx_addr,
  input logic              resv_clr,
  input logic              stx_fail
);

  localparam int GRAN_LSB = $clog2(GRANULE_BYTES);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_idle_low_R11: assert property (@(posedge clk) disable iff (rst)
    !stx_req |-> !stx_fail);

  assert_pass_consumes_R5: assert property (@(posedge clk) disable iff (rst)
    (stx_req && !stx_fail && !ldx_req) |=> !(stx_req && !stx_fail));

  assert_fail_consumes_R6: assert property (@(posedge clk) disable iff (rst)
    (stx_req && stx_fail && !ldx_req) |=> !(stx_req && !stx_fail));

  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (rst)
    resv_clr |=> !(stx_req && !stx_fail));

  assert_same_granule_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && stx_req && $past(ldx_req && !resv_clr) &&
     stx_addr[ADDR_W-1:GRAN_LSB] == $past(ldx_addr[ADDR_W-1:GRAN_LSB])) |-> !stx_fail);

  assert_other_granule_fail_R4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && stx_req && $past(ldx_req && !resv_clr) &&
     stx_addr[ADDR_W-1:GRAN_LSB] != $past(ldx_addr[ADDR_W-1:GRAN_LSB])) |-> stx_fail);

endmodule

bind excl_resv_monitor excl_resv_monitor_chk #(
  .ADDR_W(ADDR_W),
  .GRANULE_BYTES(GRANULE_BYTES)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ldx_req (ldx_req),
  .ldx_addr(ldx_addr),
  .stx_req (stx_req),
  .stx_addr(stx_addr),
  .resv_clr(resv_clr),
  .stx_fail(stx_fail)
);

// File: tb/test_excl_resv_monitor.sv
`timescale 1ns/1ps
module test_excl_resv_monitor;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ldx_req = 1'b0;
  logic [31:0] ldx_addr = '0;
  logic        stx_req = 1'b0;
  logic [31:0] stx_addr = '0;
  logic        resv_clr = 1'b0;
  logic        stx_fail;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic  exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  excl_resv_monitor i_excl_resv_monitor (
    .clk(clk), .rst(rst),
    .ldx_req(ldx_req), .ldx_addr(ldx_addr),
    .stx_req(stx_req), .stx_addr(stx_addr),
    .resv_clr(resv_clr), .stx_fail(stx_fail)
  );

  // Driver: one cycle of stimulus. The expected status is queued for every store.
  task automatic cyc(input logic ld, input logic [31:0] la,
                     input logic st, input logic [31:0] sa,
                     input logic clr, input logic exp, input string req);
    @(negedge clk);
    if (st) begin
      exp_q.push_back(exp);
      tag_q.push_back(req);
    end
    ldx_req = ld; ldx_addr = la;
    stx_req = st; stx_addr = sa;
    resv_clr = clr;
  endtask

  task automatic load(input logic [31:0] a);
    cyc(1'b1, a, 1'b0, '0, 1'b0, 1'b0, "");
  endtask

  task automatic store(input logic [31:0] a, input logic exp, input string req);
    cyc(1'b0, '0, 1'b1, a, 1'b0, exp, req);
  endtask

  task automatic idle();
    cyc(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "");
  endtask

  // Monitor: sample the status 1 ns after the inputs change, well before the next rising edge.
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (stx_req) begin
        logic  e;
        string r;
        e = exp_q.pop_front();
        r = tag_q.pop_front();
        checks++;
        if (stx_fail !== e) begin
          failures++;
          $display("FAIL %s stx_fail actual=%b expected=%b addr=%h", r, stx_fail, e, stx_addr);
        end
      end else begin
        checks++;
        if (stx_fail !== 1'b0) begin
          failures++;
          $display("FAIL R11 idle stx_fail actual=%b expected=0", stx_fail);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  localparam logic [31:0] A = 32'h0000_1000;
  localparam logic [31:0] B = 32'h0000_2000;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    store(A, 1'b1, "R1");                         // no reservation after reset
    load(A); store(A, 1'b0, "R2"); store(A, 1'b1, "R5");
    load(A); store(A + 32'd4, 1'b0, "R3");
    load(A + 32'd4); store(A + 32'd7, 1'b0, "R3");
    load(32'hFFFF_FFF8); store(32'hFFFF_FFFF, 1'b0, "R3");
    load(A); store(A + 32'd8, 1'b1, "R4"); store(A, 1'b1, "R6");
    load(A); store(A - 32'd4, 1'b1, "R4");
    load(A); cyc(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, ""); store(A, 1'b1, "R7");
    load(A); load(B); store(A, 1'b1, "R8");
    load(A); load(B); store(B, 1'b0, "R8");
    // same-cycle: store with clear is judged on the old reservation; nothing survives
    load(A); cyc(1'b0, '0, 1'b1, A, 1'b1, 1'b0, "R10"); store(A, 1'b1, "R10");
    // same-cycle: clear with load, so the clear wins
    cyc(1'b1, A, 1'b0, '0, 1'b1, 1'b0, ""); store(A, 1'b1, "R10");
    // same-cycle: load B with store A, judged on A; B survives
    load(A); cyc(1'b1, B, 1'b1, A, 1'b0, 1'b0, "R10"); store(B, 1'b0, "R10");
    // store with load of a different granule: fails on old tag, the new one survives
    load(A); cyc(1'b1, B, 1'b1, B, 1'b0, 1'b1, "R10"); store(B, 1'b0, "R9");
    // reset drops a live reservation
    load(A); idle();
    @(negedge clk); rst = 1'b1; ldx_req = 1'b0; stx_req = 1'b0;
    @(negedge clk); rst = 1'b0;
    store(A, 1'b1, "R1");
    idle(); idle();
    @(negedge clk);
    done = 1'b1;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule